// File: doc/BRIEF.md
# Real-Time Clock Register File

A byte-wide register file for a real-time clock. The host reaches it through an index/data port pair. A write to the index port selects one of fourteen registers. Later data-port reads and writes then go to that register.

Registers 0 to 9 hold the time and calendar bytes. At reset they load from parameters. Registers 10 and 11 are two status/control registers. Only a fixed set of their bits is supported, and software writes are checked against that set. Registers 12 and 13 are read-only status registers that always read as zero.

Any write the block cannot honour is refused, and it sets a sticky error output that only reset clears. While the periodic-enable bit of status register B is set, a down-counter of clock cycles produces a one-cycle interrupt pulse at a fixed interval.

The host bus is a synchronous byte strobe interface. A read returns its data one clock later on a registered output. Each read of status register A inverts the update-in-progress bit, so software that polls that bit always sees it change.

Top module: `rtc_regs`

## Requirements
- R1: A write to the index port (busSel=0) of a value from 0x0 to 0xD stores it as the selected register. A read of the index port returns the stored index in bits 3:0, with zeros above.
- R2: An index write above 0xD is not stored: the previous index is kept, and errFlag rises after that clock edge.
- R3: Registers 0x0 to 0x9 are plain read/write bytes. At reset they hold: 0x0 seconds, 0x2 minutes, 0x4 hours, 0x6 weekday, 0x7 day of month, 0x8 month, 0x9 year. Registers 0x1, 0x3 and 0x5 reset to 0.
- R4: The month parameter is zero-based (0..11) and is stored plus one (1..12). The weekday parameter counts from 0 for Sunday and is stored plus one, so 1 means Sunday.
- R5: With YEAR_BCD=1, register 0x9 holds INIT_YEAR modulo 100 as two BCD digits, tens digit in bits 7:4. With YEAR_BCD=0 it holds INIT_YEAR as a binary byte.
- R6: Status register A (0xA) resets to 0x26. The divider field 0x20 selects 32.768 kHz and the rate field 0x06 selects 1024 Hz. A write of exactly 0x26 is accepted. Any other value is not stored and sets errFlag.
- R7: Each data read of register A inverts bit 7 (update-in-progress) and returns the inverted value. After reset the reads alternate 0xA6, 0x26, 0xA6.
- R8: Status register B (0xB) resets to 0x46: bit 6 periodic enable, bit 2 binary mode, bit 1 24-hour mode. A write is accepted only if (data & ~0x48) == 0x06, where bit 3 is square-wave enable. Any other write is not stored and sets errFlag.
- R9: Registers 0xC and 0xD read as 0x00. A data write to either sets errFlag.
- R10: While bit 6 of register B is set, periodicIrq is a one-cycle pulse every TICK_CYCLES clock cycles. The timer runs from reset.
- R11: Clearing bit 6 of register B stops the pulses. Setting it while it is clear restarts the timer, with the first pulse TICK_CYCLES+1 cycles after the clock edge that captures the write. Setting it while it is already set leaves the period undisturbed.
- R12: errFlag stays high once set, until reset.
- R13: busRdata changes only on the clock edge that captures a read, and resets to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busSel | input | 1 | Port select: 0 index port, 1 data port |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| periodicIrq | output | 1 | One-cycle periodic interrupt pulse |
| errFlag | output | 1 | Sticky unsupported-access flag |

## Verification
A wrong index shows up on the very next data access as the wrong byte. It also shows directly one cycle after any read of the index port.

A corrupted status register shows on its next read. A missed update-in-progress toggle shows as two equal values on back-to-back reads of register A.

A timer that restarts at the wrong moment, or does not stop, shows as a wrong pulse spacing within one period. Such a timer is caught by measuring, in clock edges, the distance between pulses and between a write and the first pulse.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W    = 8;
  localparam int IDX_W     = 4;
  localparam int CAL_BYTES = 10;
  localparam logic [IDX_W-1:0] IDX_STAT_A = 4'hA;
  localparam logic [IDX_W-1:0] IDX_STAT_B = 4'hB;
  localparam logic [IDX_W-1:0] IDX_STAT_C = 4'hC;
  localparam logic [IDX_W-1:0] IDX_LAST   = 4'hD;

  localparam logic [DATA_W-1:0] STAT_A_INIT = 8'h26;  // 32.768 kHz divider + 1024 Hz rate
  localparam int                UIP_BIT     = 7;
  localparam logic [DATA_W-1:0] STAT_B_INIT = 8'h46;  // periodic enable, binary, 24 h
  localparam int                PIE_BIT     = 6;
  localparam logic [DATA_W-1:0] B_FREE_MASK = 8'h48;  // periodic enable, square-wave enable
  localparam logic [DATA_W-1:0] B_FIXED     = 8'h06;  // binary + 24 h must be set

  typedef struct packed {
    logic               idxRd;
    logic               dataRd;
    logic               calWr;
    logic               aWr;
    logic               bWr;
    logic [IDX_W-1:0]   idx;
    logic [DATA_W-1:0]  wdata;
  } rtcStrobe_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              busSel,
  input  logic [DATA_W-1:0] busWdata,
  output rtcStrobe_t        strobe,
  output logic              errFlag
);
  logic [IDX_W-1:0] idxQ;
  logic wrIdx, wrData, idxBad, aBad, bBad, cdWr, errSet;
  logic aOk, bOk;

  assign wrIdx  = busWr & ~busSel;
  assign wrData = busWr &  busSel;
  assign aOk    = (busWdata == STAT_A_INIT);
  assign bOk    = ((busWdata & ~B_FREE_MASK) == B_FIXED);
  assign idxBad = wrIdx && (busWdata > DATA_W'(IDX_LAST));
  assign aBad   = wrData && (idxQ == IDX_STAT_A) && !aOk;
  assign bBad   = wrData && (idxQ == IDX_STAT_B) && !bOk;
  assign cdWr   = wrData && (idxQ >= IDX_STAT_C);
  assign errSet = idxBad | aBad | bBad | cdWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ    <= '0;
      errFlag <= 1'b0;
    end else begin
      if (wrIdx && !idxBad) idxQ <= busWdata[IDX_W-1:0];
      if (errSet) errFlag <= 1'b1;
    end
  end

  always_comb begin
    strobe.idxRd  = busRd & ~busSel;
    strobe.dataRd = busRd &  busSel;
    strobe.calWr  = wrData && (idxQ < IDX_W'(CAL_BYTES));
    strobe.aWr    = wrData && (idxQ == IDX_STAT_A) && aOk;
    strobe.bWr    = wrData && (idxQ == IDX_STAT_B) && bOk;
    strobe.idx    = idxQ;
    strobe.wdata  = busWdata;
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN) idxQ <= IDX_LAST); // R1
  AST_BAD_IDX_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busSel && busWdata > 8'h0D) |=> (errFlag && $stable(idxQ))); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN) errFlag |=> errFlag); // R12
  AST_CD_WRITE_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSel && idxQ >= 4'hC) |=> errFlag); // R9
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int INIT_SEC    = 30,
  parameter int INIT_MIN    = 45,
  parameter int INIT_HOUR   = 13,
  parameter int INIT_WDAY0  = 0,
  parameter int INIT_MDAY   = 15,
  parameter int INIT_MONTH0 = 5,
  parameter int INIT_YEAR   = 124,
  parameter bit YEAR_BCD    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData,
  output logic              pieOn
);
  localparam int YEAR_LOW = INIT_YEAR % 100;
  localparam logic [DATA_W-1:0] YEAR_BYTE = YEAR_BCD
    ? DATA_W'(((YEAR_LOW / 10) << 4) | (YEAR_LOW % 10))
    : DATA_W'(INIT_YEAR);

  function automatic logic [DATA_W-1:0] calInit(input int slot);
    case (slot)
      0:       calInit = DATA_W'(INIT_SEC);
      2:       calInit = DATA_W'(INIT_MIN);
      4:       calInit = DATA_W'(INIT_HOUR);
      6:       calInit = DATA_W'(INIT_WDAY0 + 1);
      7:       calInit = DATA_W'(INIT_MDAY);
      8:       calInit = DATA_W'(INIT_MONTH0 + 1);
      9:       calInit = YEAR_BYTE;
      default: calInit = '0;
    endcase
  endfunction

  logic [DATA_W-1:0] calReg [CAL_BYTES];
  logic [DATA_W-1:0] statA, statB, rdMux;
  logic aRd;

  assign aRd   = strobe.dataRd && (strobe.idx == IDX_STAT_A);
  assign pieOn = statB[PIE_BIT];

  always_ff @(posedge clk) begin
    for (int i = 0; i < CAL_BYTES; i++) begin
      if (!rstN) calReg[i] <= calInit(i);
      else if (strobe.calWr && strobe.idx == IDX_W'(i)) calReg[i] <= strobe.wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statA <= STAT_A_INIT;
      statB <= STAT_B_INIT;
    end else begin
      if (strobe.aWr)  statA <= strobe.wdata;
      else if (aRd)    statA[UIP_BIT] <= ~statA[UIP_BIT];
      if (strobe.bWr)  statB <= strobe.wdata;
    end
  end

  always_comb begin
    if (strobe.idx < IDX_W'(CAL_BYTES)) rdMux = calReg[strobe.idx];
    else if (strobe.idx == IDX_STAT_A)  rdMux = statA ^ (DATA_W'(1) << UIP_BIT);
    else if (strobe.idx == IDX_STAT_B)  rdMux = statB;
    else                                rdMux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdData <= '0;
    else if (strobe.idxRd)  rdData <= {{(DATA_W-IDX_W){1'b0}}, strobe.idx};
    else if (strobe.dataRd) rdData <= rdMux;
  end

  AST_A_FIXED_BITS: assert property (@(posedge clk) disable iff (!rstN) statA[6:0] == 7'h26); // R6
  AST_A_UIP_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
    (aRd && !strobe.aWr) |=> (statA[UIP_BIT] != $past(statA[UIP_BIT]))); // R7
  AST_B_SHAPE: assert property (@(posedge clk) disable iff (!rstN) (statB & ~B_FREE_MASK) == B_FIXED); // R8
  AST_CD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataRd && strobe.idx >= IDX_STAT_C) |=> rdData == 8'h00); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.idxRd && !strobe.dataRd) |=> $stable(rdData)); // R13
endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
  parameter int TICK_CYCLES = 40
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  output logic irq
);
  localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic enQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= RELOAD;
      enQ <= 1'b1;
      irq <= 1'b0;
    end else begin
      enQ <= enable;
      if (!enable) begin
        irq <= 1'b0;
      end else if (!enQ) begin
        cnt <= RELOAD;
        irq <= 1'b0;
      end else if (cnt == '0) begin
        cnt <= RELOAD;
        irq <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
        irq <= 1'b0;
      end
    end
  end

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) irq |=> !irq); // R10
  AST_IRQ_STOPPED: assert property (@(posedge clk) disable iff (!rstN) !enable |=> !irq); // R11
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int TICK_CYCLES = 40,
  parameter int INIT_SEC    = 30,
  parameter int INIT_MIN    = 45,
  parameter int INIT_HOUR   = 13,
  parameter int INIT_WDAY0  = 0,
  parameter int INIT_MDAY   = 15,
  parameter int INIT_MONTH0 = 5,
  parameter int INIT_YEAR   = 124,
  parameter bit YEAR_BCD    = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic       busRd,
  input  logic       busSel,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       periodicIrq,
  output logic       errFlag
);
  rtcStrobe_t strobe;
  logic pieOn;

  rtc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busSel(busSel),
    .busWdata(busWdata), .strobe(strobe), .errFlag(errFlag)
  );

  rtc_datapath #(
    .INIT_SEC(INIT_SEC), .INIT_MIN(INIT_MIN), .INIT_HOUR(INIT_HOUR),
    .INIT_WDAY0(INIT_WDAY0), .INIT_MDAY(INIT_MDAY), .INIT_MONTH0(INIT_MONTH0),
    .INIT_YEAR(INIT_YEAR), .YEAR_BCD(YEAR_BCD)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(busRdata), .pieOn(pieOn)
  );

  rtc_periodic #(.TICK_CYCLES(TICK_CYCLES)) u_periodic (
    .clk(clk), .rstN(rstN), .enable(pieOn), .irq(periodicIrq)
  );
endmodule

// File: tb/test_rtc_regs.sv
`timescale 1ns/1ps
module test_rtc_regs;
  localparam int TICK = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0, busSel = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata, rdBin;
  logic periodicIrq, errFlag, irqBin, errBin;

  int checks = 0, fails = 0;
  int edgeN = 0, pulseCnt = 0, lastPulse = 0, prevPulse = 0, wideCnt = 0;
  logic prevIrq = 1'b0;

  always #5 clk = ~clk;

  rtc_regs #(.TICK_CYCLES(TICK)) i_rtc_regs (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busSel(busSel),
    .busWdata(busWdata), .busRdata(busRdata), .periodicIrq(periodicIrq), .errFlag(errFlag)
  );

  rtc_regs #(.TICK_CYCLES(TICK), .YEAR_BCD(1'b0)) i_rtc_regs_bin (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busSel(busSel),
    .busWdata(busWdata), .busRdata(rdBin), .periodicIrq(irqBin), .errFlag(errBin)
  );

  always @(posedge clk) edgeN <= edgeN + 1;

  always @(negedge clk) begin
    if (!rstN) begin
      prevIrq <= 1'b0;
    end else begin
      if (periodicIrq) begin
        prevPulse = lastPulse;
        lastPulse = edgeN;
        pulseCnt  = pulseCnt + 1;
        if (prevIrq) wideCnt = wideCnt + 1;
      end
      prevIrq <= periodicIrq;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; busWr = 0; busRd = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic busWrite(input logic sel, input logic [7:0] d, output int capEdge);
    @(negedge clk);
    busSel = sel; busWdata = d; busWr = 1'b1;
    capEdge = edgeN + 1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic sel, output logic [7:0] d);
    @(negedge clk);
    busSel = sel; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic writeReg(input logic [7:0] idx, input logic [7:0] d, output int capEdge);
    int e;
    busWrite(1'b0, idx, e);
    busWrite(1'b1, d, capEdge);
  endtask

  task automatic readReg(input logic [7:0] idx, output logic [7:0] d);
    int e;
    busWrite(1'b0, idx, e);
    busRead(1'b1, d);
  endtask

  task automatic waitPulse(input int startCnt);
    for (int i = 0; i < 4 * TICK && pulseCnt == startCnt; i++) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d;
    doReset();
    @(negedge clk);
    check("R13 reset rdata", busRdata, 8'h00);
    check("R12 reset errFlag", errFlag, 0);
    busRead(1'b0, d);
    check("R1 reset index", d, 0);
  endtask

  task automatic testCalInit();
    logic [7:0] d;
    logic [7:0] expv [10] = '{8'h1E, 8'h00, 8'h2D, 8'h00, 8'h0D, 8'h00, 8'h01, 8'h0F, 8'h06, 8'h24};
    doReset();
    for (int i = 0; i < 10; i++) begin
      readReg(8'(i), d);
      if (i == 6 || i == 8) check("R4 weekday/month init", d, expv[i]);
      else if (i == 9)      check("R5 BCD year", d, expv[i]);
      else                  check("R3 calendar init", d, expv[i]);
      if (i == 9) check("R5 binary year", rdBin, 8'h7C);
    end
  endtask

  task automatic testCalRw();
    logic [7:0] d;
    int e;
    doReset();
    writeReg(8'h03, 8'h5A, e);
    writeReg(8'h09, 8'hC3, e);
    readReg(8'h03, d);
    check("R3 calendar rw idx3", d, 8'h5A);
    readReg(8'h09, d);
    check("R3 calendar rw idx9", d, 8'hC3);
    writeReg(8'h00, 8'h11, e);
    repeat (3) @(negedge clk);
    check("R13 rdata holds without read", busRdata, 8'hC3);
    check("R3 legal writes raise no error", errFlag, 0);
  endtask

  task automatic testIndex();
    logic [7:0] d;
    int e;
    doReset();
    busWrite(1'b0, 8'h0D, e);
    busRead(1'b0, d);
    check("R1 index 0xD stored", d, 8'h0D);
    check("R1 no error", errFlag, 0);
    busWrite(1'b0, 8'h0E, e);
    check("R2 error on index 0xE", errFlag, 1);
    busRead(1'b0, d);
    check("R2 index kept", d, 8'h0D);
    writeReg(8'h02, 8'h07, e);
    repeat (5) @(negedge clk);
    check("R12 error sticky", errFlag, 1);
  endtask

  task automatic testStatA();
    logic [7:0] d;
    int e;
    doReset();
    readReg(8'h0A, d);
    check("R7 first A read", d, 8'hA6);
    busRead(1'b1, d);
    check("R7 second A read", d, 8'h26);
    busRead(1'b1, d);
    check("R7 third A read", d, 8'hA6);
    busWrite(1'b1, 8'h26, e);
    check("R6 legal A write no error", errFlag, 0);
    busWrite(1'b1, 8'h27, e);
    check("R6 illegal A write error", errFlag, 1);
    busRead(1'b1, d);
    check("R6 A low bits unchanged", d & 8'h7F, 8'h26);
  endtask

  task automatic testStatB();
    logic [7:0] d;
    int e;
    doReset();
    readReg(8'h0B, d);
    check("R8 B reset", d, 8'h46);
    busWrite(1'b1, 8'h0E, e);
    busRead(1'b1, d);
    check("R8 legal B write", d, 8'h0E);
    check("R8 legal B no error", errFlag, 0);
    busWrite(1'b1, 8'h04, e);
    check("R8 illegal B error", errFlag, 1);
    busRead(1'b1, d);
    check("R8 illegal B not stored", d, 8'h0E);
  endtask

  task automatic testStatCD();
    logic [7:0] d;
    int e;
    doReset();
    readReg(8'h0C, d);
    check("R9 C reads zero", d, 0);
    readReg(8'h0D, d);
    check("R9 D reads zero", d, 0);
    check("R9 reads no error", errFlag, 0);
    writeReg(8'h0C, 8'h00, e);
    check("R9 C write error", errFlag, 1);
    doReset();
    writeReg(8'h0D, 8'h80, e);
    check("R9 D write error", errFlag, 1);
  endtask

  task automatic testPeriodic();
    int e, c0;
    doReset();
    waitPulse(pulseCnt);
    c0 = pulseCnt;
    waitPulse(c0);
    check("R10 period from reset", lastPulse - prevPulse, TICK);
    check("R10 pulse one cycle wide", wideCnt, 0);
    writeReg(8'h0B, 8'h06, e);
    repeat (2) @(negedge clk);
    c0 = pulseCnt;
    repeat (3 * TICK) @(negedge clk);
    check("R11 stopped no pulses", pulseCnt - c0, 0);
    c0 = pulseCnt;
    writeReg(8'h0B, 8'h46, e);
    waitPulse(c0);
    check("R11 start delay", lastPulse - e, TICK + 1);
    c0 = pulseCnt;
    repeat (TICK / 3) @(negedge clk);
    writeReg(8'h0B, 8'h4E, e);
    waitPulse(c0);
    check("R11 rewrite keeps period", lastPulse - prevPulse, TICK);
    check("R10 pulse one cycle wide later", wideCnt, 0);
  endtask

  initial begin
    #(1_500_000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    testReset();
    testCalInit();
    testCalRw();
    testIndex();
    testStatA();
    testStatB();
    testStatCD();
    testPeriodic();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule